// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block sits next to an SDRAM controller's command path and works out the column address for every data beat of a read or write burst. The controller hands it the address-bus value whenever it programs the memory's mode register. From that word the block keeps the burst length, the wrap ordering (sequential or interleaved) and the option that limits writes to a single beat. When the controller starts a read or write, it passes the starting column. The block then presents one column per clock, marks the final beat, and goes idle.

Full-page bursts use sequential ordering across the whole row and keep running until the controller stops them. A new start during a burst abandons the old one at once, and a stop strobe ends any burst early. Mode codes that the memory reserves, and a full-page length combined with interleaved ordering, raise an error flag. The block then runs single-beat bursts until a legal mode is loaded.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, `col_valid`, `col_last` and `mode_err` are 0 and the mode is burst length 1, sequential, writes not forced to one beat.
- R2: On a cycle with `mode_load` high, the block captures `mode_word`. Bits 2:0 select the length (000=1, 001=2, 010=4, 011=8, 111=full page), bit 3 selects the ordering (0 sequential, 1 interleaved) and bit 9 forces single-beat writes. The new mode applies to starts in later cycles.
- R3: When `start` is sampled high, `col_out` equals `start_col` and `col_valid` is 1 in the next cycle, and one further beat follows on each cycle after that.
- R4: With sequential ordering and length L, beat i is `start_col` with its low log2(L) bits replaced by (low bits of `start_col` + i) mod L.
- R5: With interleaved ordering and length L, beat i is `start_col` with its low log2(L) bits replaced by (low bits of `start_col`) XOR i.
- R6: `col_last` is 1 exactly on the final beat of a finite burst and never without `col_valid`. In the cycle after the final beat, `col_valid` is 0 unless a new start was sampled.
- R7: A full-page burst steps sequentially through all 2^COL_W columns, wraps from the top column to 0, never raises `col_last`, and runs until `stop` or a new `start`.
- R8: `stop` sampled high without `start` makes `col_valid` and `col_last` 0 in the next cycle. A stop while idle has no effect, and a stop in the same cycle as `start` is ignored so the new burst runs.
- R9: A `start` sampled during a burst abandons it, and the next cycle shows beat 0 of the new burst.
- R10: When bit 9 of the loaded mode is 1, a start with `start_wr`=1 gives a one-beat burst. A start with `start_wr`=0 keeps the programmed length and ordering.
- R11: Loading length code 100, 101 or 110 sets `mode_err` to 1 in the next cycle, and later bursts have length 1. A later legal load clears `mode_err`.
- R12: Loading length code 111 with bit 3 set (full page with interleaving) sets `mode_err` to 1, and later bursts have length 1.
- R13: A mode load during a burst does not change the length or ordering of that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_load | input | 1 | Capture `mode_word` as the new mode |
| mode_word | input | MODE_W | Address-bus value of the mode-register load |
| start | input | 1 | Begin a burst at `start_col` |
| start_wr | input | 1 | 1 when the starting command is a write |
| start_col | input | COL_W | Starting column of the burst |
| stop | input | 1 | End the running burst |
| col_out | output | COL_W | Column of the current beat |
| col_valid | output | 1 | `col_out` holds a beat |
| col_last | output | 1 | Current beat is the last of a finite burst |
| mode_err | output | 1 | Loaded mode was reserved or illegal |

## Verification
The bench uses starting columns in the middle of an aligned block. A generator that only counts upward would run past the block edge instead of wrapping, and one that swaps the two orderings would give the wrong order in an eight-beat interleaved burst. It runs a full-page burst across the top of the row, which catches a length mask applied to full page or a missing `col_last` suppression. It also restarts and stops bursts in mid-flight and sends stop and start in the same cycle, so wrong priority shows up as a missing or extra beat. It checks single-beat writes against reads in the same mode, loads reserved and illegal codes, and reloads the mode during a burst, where a design that decodes the mode live would cut the burst short.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;

  typedef enum logic [2:0] {
    BLEN_1    = 3'd0,
    BLEN_2    = 3'd1,
    BLEN_4    = 3'd2,
    BLEN_8    = 3'd3,
    BLEN_PAGE = 3'd4
  } blen_e;

  typedef struct packed {
    blen_e  blen;
    order_e order;
    logic   wr_one;
    logic   err;
  } mode_cfg_t;

  localparam mode_cfg_t MODE_RESET = '{blen: BLEN_1, order: ORD_SEQ, wr_one: 1'b0, err: 1'b0};

  function automatic mode_cfg_t decode_mode(input logic [2:0] code, input logic ilv, input logic wone);
    mode_cfg_t m;
    m.order  = ilv ? ORD_ILV : ORD_SEQ;
    m.wr_one = wone;
    m.err    = 1'b0;
    unique case (code)
      3'b000:  m.blen = BLEN_1;
      3'b001:  m.blen = BLEN_2;
      3'b010:  m.blen = BLEN_4;
      3'b011:  m.blen = BLEN_8;
      3'b111:  m.blen = BLEN_PAGE;
      default: begin
        m.blen = BLEN_1;
        m.err  = 1'b1;
      end
    endcase
    if (m.blen == BLEN_PAGE && ilv) begin
      m.blen  = BLEN_1;
      m.order = ORD_SEQ;
      m.err   = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/colgen_mode_reg.sv
module colgen_mode_reg
  import colgen_pkg::*;
#(
  parameter int MODE_W   = 12,
  parameter int LEN_LSB  = 0,
  parameter int TYPE_BIT = 3,
  parameter int WONE_BIT = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [MODE_W-1:0] word,
  output mode_cfg_t         cfg
);

  mode_cfg_t cfg_q;
  mode_cfg_t cfg_d;

  always_comb begin
    cfg_d = decode_mode(word[LEN_LSB +: 3], word[TYPE_BIT], word[WONE_BIT]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= MODE_RESET;
    end else if (load) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/colgen_addr_calc.sv
module colgen_addr_calc #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] idx,
  input  logic [COL_W-1:0] mask,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);

  logic [COL_W-1:0] step_sum;
  logic [COL_W-1:0] step_mix;
  logic [COL_W-1:0] low_part;

  always_comb begin
    step_sum = base + idx;
    step_mix = base ^ idx;
    low_part = ilv ? step_mix : step_sum;
    col      = (base & ~mask) | (low_part & mask);
  end

endmodule

// File: rtl/colgen_seq.sv
module colgen_seq
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  mode_cfg_t        cfg,
  input  logic             start,
  input  logic             start_wr,
  input  logic [COL_W-1:0] start_col,
  input  logic             stop,
  output logic [COL_W-1:0] col_out,
  output logic             col_valid,
  output logic             col_last
);

  localparam logic [COL_W-1:0] ONE_COL = COL_W'(1);

  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] idx_q;
  logic [COL_W-1:0] mask_q;
  logic             ilv_q;
  logic             page_q;
  logic [COL_W-1:0] col_q;
  logic             valid_q;
  logic             last_q;

  blen_e            eff_len;
  logic [COL_W-1:0] mask_s;
  logic             page_s;
  logic [COL_W-1:0] idx_n;
  logic [COL_W-1:0] col_n;

  always_comb begin
    eff_len = (start_wr && cfg.wr_one) ? BLEN_1 : cfg.blen;
    page_s  = (eff_len == BLEN_PAGE);
    unique case (eff_len)
      BLEN_1:    mask_s = '0;
      BLEN_2:    mask_s = COL_W'(1);
      BLEN_4:    mask_s = COL_W'(3);
      BLEN_8:    mask_s = COL_W'(7);
      BLEN_PAGE: mask_s = '1;
      default:   mask_s = '0;
    endcase
    idx_n = idx_q + ONE_COL;
  end

  colgen_addr_calc #(.COL_W(COL_W)) calc_i (
    .base (base_q),
    .idx  (idx_n),
    .mask (mask_q),
    .ilv  (ilv_q),
    .col  (col_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      idx_q   <= '0;
      mask_q  <= '0;
      ilv_q   <= 1'b0;
      page_q  <= 1'b0;
      col_q   <= '0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end else if (start) begin
      base_q  <= start_col;
      idx_q   <= '0;
      mask_q  <= mask_s;
      ilv_q   <= (cfg.order == ORD_ILV) && !page_s;
      page_q  <= page_s;
      col_q   <= start_col;
      valid_q <= 1'b1;
      last_q  <= !page_s && (mask_s == '0);
    end else if (stop) begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end else if (valid_q) begin
      if (last_q) begin
        valid_q <= 1'b0;
        last_q  <= 1'b0;
      end else begin
        idx_q  <= idx_n;
        col_q  <= col_n;
        last_q <= !page_q && (idx_n == mask_q);
      end
    end
  end

  assign col_out   = col_q;
  assign col_valid = valid_q;
  assign col_last  = last_q;

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W    = 8,
  parameter int MODE_W   = 12,
  parameter int TYPE_BIT = 3,
  parameter int WONE_BIT = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_load,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              start,
  input  logic              start_wr,
  input  logic [COL_W-1:0]  start_col,
  input  logic              stop,
  output logic [COL_W-1:0]  col_out,
  output logic              col_valid,
  output logic              col_last,
  output logic              mode_err
);

  mode_cfg_t cfg;

  colgen_mode_reg #(
    .MODE_W   (MODE_W),
    .LEN_LSB  (0),
    .TYPE_BIT (TYPE_BIT),
    .WONE_BIT (WONE_BIT)
  ) mode_i (
    .clk  (clk),
    .rst  (rst),
    .load (mode_load),
    .word (mode_word),
    .cfg  (cfg)
  );

  colgen_seq #(.COL_W(COL_W)) seq_i (
    .clk       (clk),
    .rst       (rst),
    .cfg       (cfg),
    .start     (start),
    .start_wr  (start_wr),
    .start_col (start_col),
    .stop      (stop),
    .col_out   (col_out),
    .col_valid (col_valid),
    .col_last  (col_last)
  );

  assign mode_err = cfg.err;

endmodule

// File: rtl/colgen_chk.sv
module colgen_chk #(
  parameter int COL_W    = 8,
  parameter int MODE_W   = 12,
  parameter int TYPE_BIT = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_load,
  input logic [MODE_W-1:0] mode_word,
  input logic              start,
  input logic [COL_W-1:0]  start_col,
  input logic              stop,
  input logic [COL_W-1:0]  col_out,
  input logic              col_valid,
  input logic              col_last,
  input logic              mode_err
);

  logic code_rsvd;
  logic code_bad_page;
  assign code_rsvd     = (mode_word[2:0] == 3'b100) || (mode_word[2:0] == 3'b101) || (mode_word[2:0] == 3'b110);
  assign code_bad_page = (mode_word[2:0] == 3'b111) && mode_word[TYPE_BIT];

  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst) col_last |-> col_valid); // R6
  AST_START_BEAT0: assert property (@(posedge clk) disable iff (rst) start |=> (col_valid && col_out == $past(start_col))); // R3
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (rst) (stop && !start) |=> !col_valid); // R8
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst) (col_last && !start) |=> !col_valid); // R6
  AST_RSVD_FLAGS: assert property (@(posedge clk) disable iff (rst) (mode_load && code_rsvd) |=> mode_err); // R11
  AST_BAD_PAGE_FLAGS: assert property (@(posedge clk) disable iff (rst) (mode_load && code_bad_page) |=> mode_err); // R12
  AST_LEGAL_CLEARS: assert property (@(posedge clk) disable iff (rst) (mode_load && !code_rsvd && !code_bad_page) |=> !mode_err); // R2

endmodule

bind sdram_burst_colgen colgen_chk #(
  .COL_W    (COL_W),
  .MODE_W   (MODE_W),
  .TYPE_BIT (TYPE_BIT)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .mode_load (mode_load),
  .mode_word (mode_word),
  .start     (start),
  .start_col (start_col),
  .stop      (stop),
  .col_out   (col_out),
  .col_valid (col_valid),
  .col_last  (col_last),
  .mode_err  (mode_err)
);

// File: tb/sdram_burst_colgen_tb_top.sv
`timescale 1ns/1ps
module sdram_burst_colgen_tb_top;

  localparam int COL_W  = 8;
  localparam int MODE_W = 12;
  localparam int NCOL   = 1 << COL_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              mode_load = 1'b0;
  logic [MODE_W-1:0] mode_word = '0;
  logic              start = 1'b0;
  logic              start_wr = 1'b0;
  logic [COL_W-1:0]  start_col = '0;
  logic              stop = 1'b0;
  logic [COL_W-1:0]  col_out;
  logic              col_valid;
  logic              col_last;
  logic              mode_err;

  always #10 clk = ~clk;

  sdram_burst_colgen #(.COL_W(COL_W), .MODE_W(MODE_W)) dut_i (
    .clk(clk), .rst(rst), .mode_load(mode_load), .mode_word(mode_word),
    .start(start), .start_wr(start_wr), .start_col(start_col), .stop(stop),
    .col_out(col_out), .col_valid(col_valid), .col_last(col_last), .mode_err(mode_err)
  );

  int tests = 0;
  int fails = 0;

  // scoreboard queues
  int    q_col[$];
  bit    q_last[$];
  string q_tag[$];

  // bench-side mode model: m_len 0 means full page
  int m_len = 1;
  bit m_ilv = 1'b0;
  bit m_one = 1'b0;

  function automatic int exp_col(int sc, int i, int len, bit ilv);
    int blk;
    if (len == 0) return (sc + i) % NCOL;
    blk = sc - (sc % len);
    if (ilv) return blk + ((sc % len) ^ i);
    return blk + (((sc % len) + i) % len);
  endfunction

  task automatic tick(int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  // driver: push the first n expected beats of a burst
  task automatic push_burst(int sc, bit wr, int n, string tag);
    int len;
    int cnt;
    len = (wr && m_one) ? 1 : m_len;
    cnt = (len == 0 || n < len) ? n : len;
    for (int i = 0; i < cnt; i++) begin
      q_col.push_back(exp_col(sc, i, len, m_ilv));
      q_last.push_back(len != 0 && i == len - 1);
      q_tag.push_back(tag);
    end
  endtask

  task automatic pulse_start(int sc, bit wr, bit with_stop);
    start = 1'b1; start_wr = wr; start_col = COL_W'(sc); stop = with_stop;
    @(posedge clk);
    #1;
    start = 1'b0; start_wr = 1'b0; stop = 1'b0;
  endtask

  task automatic pulse_stop();
    stop = 1'b1;
    @(posedge clk);
    #1;
    stop = 1'b0;
  endtask

  task automatic load_mode(logic [MODE_W-1:0] w);
    int code;
    mode_load = 1'b1; mode_word = w;
    @(posedge clk);
    #1;
    mode_load = 1'b0;
    code = int'(w[2:0]);
    m_one = w[9];
    m_ilv = w[3];
    case (code)
      0: m_len = 1;
      1: m_len = 2;
      2: m_len = 4;
      3: m_len = 8;
      7: m_len = w[3] ? 1 : 0;
      default: m_len = 1;
    endcase
    if (m_len == 1 || m_len == 0) m_ilv = (code == 7 && w[3]) ? 1'b0 : m_ilv;
  endtask

  task automatic check_bit(logic act, logic exp, string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic check_err(logic exp, string tag);
    @(negedge clk);
    check_bit(mode_err, exp, tag);
    @(posedge clk);
    #1;
  endtask

  task automatic drain(int n, string tag);
    tick(n);
    tests++;
    if (q_col.size() != 0) begin
      fails++;
      $display("FAIL %s: actual %0d beats missing expected 0", tag, q_col.size());
      q_col.delete(); q_last.delete(); q_tag.delete();
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && col_valid) begin
      tests++;
      if (q_col.size() == 0) begin
        fails++;
        $display("FAIL R6 unexpected beat: actual col %0d last %0b expected no beat", col_out, col_last);
      end else begin
        int    ec;
        bit    el;
        string et;
        ec = q_col.pop_front();
        el = q_last.pop_front();
        et = q_tag.pop_front();
        if (int'(col_out) != ec || col_last !== el) begin
          fails++;
          $display("FAIL %s: actual col %0d last %0b expected col %0d last %0b", et, col_out, col_last, ec, el);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tick(3);
    @(negedge clk);
    check_bit(col_valid, 1'b0, "R1 valid at reset");
    check_bit(col_last, 1'b0, "R1 last at reset");
    check_bit(mode_err, 1'b0, "R1 err at reset");
    rst = 1'b0;
    @(posedge clk);
    #1;

    // R1 default length 1
    push_burst(37, 1'b0, 99, "R1 default one beat");
    pulse_start(37, 1'b0, 1'b0);
    drain(4, "R1 drain");

    // R2 / R4 sequential length 4 mid-block start
    load_mode(12'h002);
    check_err(1'b0, "R2 legal load");
    push_burst(6, 1'b0, 99, "R4 seq len4");
    pulse_start(6, 1'b0, 1'b0);
    drain(6, "R6 seq len4 count");

    load_mode(12'h003);
    push_burst(13, 1'b0, 99, "R4 seq len8");
    pulse_start(13, 1'b0, 1'b0);
    drain(10, "R6 seq len8 count");

    load_mode(12'h001);
    push_burst(9, 1'b0, 99, "R4 seq len2");
    pulse_start(9, 1'b0, 1'b0);
    drain(4, "R6 seq len2 count");

    // R5 interleave
    load_mode(12'h00B);
    push_burst(13, 1'b0, 99, "R5 ilv len8");
    pulse_start(13, 1'b0, 1'b0);
    drain(10, "R5 ilv len8 count");

    load_mode(12'h00A);
    push_burst(6, 1'b0, 99, "R5 ilv len4");
    pulse_start(6, 1'b0, 1'b0);
    drain(6, "R5 ilv len4 count");

    // R7 full page across top of row, stopped after 8 beats (R8)
    load_mode(12'h007);
    check_err(1'b0, "R7 page load");
    push_burst(250, 1'b0, 8, "R7 full page wrap");
    pulse_start(250, 1'b0, 1'b0);
    tick(7);
    pulse_stop();
    drain(4, "R8 stop ends page");

    // R8 stop while idle
    pulse_stop();
    @(negedge clk);
    check_bit(col_valid, 1'b0, "R8 stop while idle");
    @(posedge clk);
    #1;

    // R9 restart after 3 beats
    load_mode(12'h003);
    push_burst(16, 1'b0, 3, "R9 first burst");
    pulse_start(16, 1'b0, 1'b0);
    tick(2);
    push_burst(40, 1'b0, 99, "R9 second burst");
    pulse_start(40, 1'b0, 1'b0);
    drain(10, "R9 count");

    // R10 single-beat writes
    load_mode(12'h202);
    push_burst(5, 1'b1, 99, "R10 write one beat");
    pulse_start(5, 1'b1, 1'b0);
    drain(3, "R10 write count");
    push_burst(5, 1'b0, 99, "R10 read keeps len4");
    pulse_start(5, 1'b0, 1'b0);
    drain(6, "R10 read count");

    // R11 reserved code
    load_mode(12'h005);
    check_err(1'b1, "R11 reserved flags");
    push_burst(20, 1'b0, 99, "R11 reserved len1");
    pulse_start(20, 1'b0, 1'b0);
    drain(4, "R11 count");
    load_mode(12'h003);
    check_err(1'b0, "R11 legal clears");

    // R12 full page with interleave
    load_mode(12'h00F);
    check_err(1'b1, "R12 page ilv flags");
    push_burst(20, 1'b0, 99, "R12 len1");
    pulse_start(20, 1'b0, 1'b0);
    drain(4, "R12 count");

    // R13 mode load mid-burst
    load_mode(12'h003);
    push_burst(0, 1'b0, 99, "R13 burst unchanged");
    pulse_start(0, 1'b0, 1'b0);
    tick(1);
    load_mode(12'h001);
    drain(10, "R13 count");
    push_burst(0, 1'b0, 99, "R13 next burst new len");
    pulse_start(0, 1'b0, 1'b0);
    drain(4, "R13 next count");

    // R8 start and stop in the same cycle: start wins
    push_burst(4, 1'b0, 99, "R8 start beats stop");
    pulse_start(4, 1'b0, 1'b1);
    drain(4, "R8 same-cycle count");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule